// File: doc/BRIEF.md
# Sector Verify Sequencer

This block runs the sector-verify command of a floppy-style disk controller. After the command bytes have been parsed, a start pulse loads the verify parameters: the mode bit with the drive and head selects, the first sector, the last sector of the track, the sector count and the number of sectors on one side. The block then follows a sector reader. That reader reports each sector it has checked, and it only accepts sectors that carry a normal data address mark. No data is sent to the host.

The block decides when the command is finished. In counting mode, it stops after a programmed number of sectors. In track mode, it stops when the sector just checked is the last sector of the track. Before any sector is read, the block checks the parameters. If the last sector of the track lies beyond the side's sector count, the command ends at once with an error code. The terminal-count input of the transfer path has no influence, because this command moves no data.

Top module: `sector_verify_seq`

## Requirements
- R1: On an accepted start, `mode_drv_head` is latched. Bit 7 selects counting mode (1) or track mode (0). Bits 1:0 go to `drive_sel` and bit 2 goes to `head_sel`. These outputs hold their values until the next accepted start.
- R2: In counting mode, `done` rises the cycle after the rising edge on which the Nth accepted `sector_checked` pulse is sampled, where N = `sec_count`.
- R3: In counting mode, a `sec_count` of 0 verifies 256 sectors.
- R4: In track mode, the command ends on the pulse whose current sector equals `eot_sector`. `sec_count` has no effect in this mode.
- R5: `term_count` has no effect on any output.
- R6: If `eot_sector` > `sectors_per_side`, the block goes from the check cycle straight to `done` with status 2'b10. It steps no sector, so `cur_sector` keeps the start value.
- R7: `done` is high for exactly one cycle. On normal completion `status` becomes 2'b01. `status` reads 2'b00 from an accepted start until completion, and it holds its final value until the next accepted start.
- R8: `cur_sector` loads `start_sector` on start. It then increments by 1, modulo 256, on each accepted `sector_checked` pulse, including the final one.
- R9: `start` is ignored unless the block is idle. `sector_checked` is only accepted while sectors are being stepped.
- R10: `busy` is high from the cycle after an accepted start until `done` rises. It is low in the `done` cycle and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for a verify command |
| mode_drv_head | input | 8 | Mode bit 7, head bit 2, drive bits 1:0 |
| start_sector | input | 8 | First sector to check |
| eot_sector | input | 8 | Last sector number of the track |
| sec_count | input | 8 | Sectors to check in counting mode (0 = 256) |
| sectors_per_side | input | 8 | Sectors present on one side |
| sector_checked | input | 1 | Pulse from the reader: one sector verified |
| term_count | input | 1 | Terminal count from the transfer path (ignored) |
| cur_sector | output | 8 | Sector number now being checked |
| drive_sel | output | 2 | Latched drive select |
| head_sel | output | 1 | Latched head select |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| status | output | 2 | 00 none, 01 normal end, 10 parameter error |

## Verification
The bench drives a count of zero and expects 256 steps. A design that treated zero literally would stop at once or never stop. A run that starts near sector 255 checks that the sector number wraps, and a track-mode run with a junk count checks that only the track end matters. The error case sets the track end one past the side size and expects an immediate error with no step taken. Pulses of the terminal-count input, restarts issued mid-command and reader pulses sent while idle must all leave the outputs exactly as the reference model predicts, so a design that honoured any of them would show a wrong sector, wrong selects or an early strobe.

// File: rtl/sector_verify_seq.sv
module sector_verify_seq #(
  parameter int SW = 8,
  localparam int CW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    mode_drv_head,
  input  logic [SW-1:0] start_sector,
  input  logic [SW-1:0] eot_sector,
  input  logic [SW-1:0] sec_count,
  input  logic [SW-1:0] sectors_per_side,
  input  logic          sector_checked,
  input  logic          term_count,
  output logic [SW-1:0] cur_sector,
  output logic [1:0]    drive_sel,
  output logic          head_sel,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_RUN, S_DONE} st_t;
  localparam logic [1:0] ST_NONE = 2'b00, ST_OK = 2'b01, ST_ERR = 2'b10;

  st_t           st;
  logic          count_mode;
  logic [SW-1:0] eot_q, spp_q;
  logic [CW-1:0] target_q, cnt_q;
  logic          step, finish;

  assign step   = (st == S_RUN) && sector_checked;
  assign finish = count_mode ? (cnt_q + CW'(1) == target_q) : (cur_sector == eot_q);
  assign busy   = (st == S_CHECK) || (st == S_RUN);
  assign done   = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      count_mode <= 1'b0;
      eot_q <= '0;
      spp_q <= '0;
      target_q <= '0;
      cnt_q <= '0;
      cur_sector <= '0;
      drive_sel <= '0;
      head_sel <= 1'b0;
      status <= ST_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          count_mode <= mode_drv_head[7];
          head_sel   <= mode_drv_head[2];
          drive_sel  <= mode_drv_head[1:0];
          eot_q      <= eot_sector;
          spp_q      <= sectors_per_side;
          target_q   <= (sec_count == '0) ? (CW'(1) << SW) : CW'(sec_count);
          cnt_q      <= '0;
          cur_sector <= start_sector;
          status     <= ST_NONE;
          st         <= S_CHECK;
        end
        S_CHECK: begin
          if (eot_q > spp_q) begin
            status <= ST_ERR;
            st     <= S_DONE;
          end else begin
            st <= S_RUN;
          end
        end
        S_RUN: if (step) begin
          cnt_q      <= cnt_q + CW'(1);
          cur_sector <= cur_sector + SW'(1);
          if (finish) begin
            status <= ST_OK;
            st     <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && eot_q > spp_q) |=> (done && status == ST_ERR && $stable(cur_sector)));

  p_sector_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_sector == $past(cur_sector) + SW'(1)));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(drive_sel) && $stable(head_sel)));

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_mode |-> (cnt_q <= target_q));

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status == ST_NONE));

  p_tc_no_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !sector_checked && term_count) |=> (busy && $stable(cur_sector)));
endmodule

// File: tb/sector_verify_seq_test.sv
module sector_verify_seq_test;
  logic clk = 0, rst_n = 0, start = 0, sector_checked = 0, term_count = 0;
  logic [7:0] mode_drv_head = 0, start_sector = 0, eot_sector = 0, sec_count = 0, sectors_per_side = 0;
  logic [7:0] cur_sector;
  logic [1:0] drive_sel, status;
  logic head_sel, busy, done;

  sector_verify_seq uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R10";
  int ph = 0, m_sec = 0, m_cnt = 0, m_tgt = 0, m_eot = 0, m_spp = 0, m_stat = 0, m_drv = 0, m_head = 0;
  bit m_ec = 0;
  bit fin;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ph = 0; m_sec = 0; m_stat = 0; m_drv = 0; m_head = 0;
    end else case (ph)
      0: if (start) begin
        m_ec = mode_drv_head[7]; m_head = mode_drv_head[2]; m_drv = mode_drv_head[1:0];
        m_eot = eot_sector; m_spp = sectors_per_side;
        m_tgt = (sec_count == 0) ? 256 : sec_count;
        m_cnt = 0; m_sec = start_sector; m_stat = 0; ph = 1;
      end
      1: if (m_eot > m_spp) begin m_stat = 2; ph = 3; end else ph = 2;
      2: if (sector_checked) begin
        fin = m_ec ? (m_cnt + 1 == m_tgt) : (m_sec == m_eot);
        m_cnt++; m_sec = (m_sec + 1) % 256;
        if (fin) begin m_stat = 1; ph = 3; end
      end
      default: ph = 0;
    endcase
  end

  task automatic cmp(string f, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, f, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp("busy", busy, (ph == 1 || ph == 2));
    cmp("done", done, ph == 3);
    cmp("status", status, m_stat);
    cmp("cur_sector", cur_sector, m_sec);
    cmp("drive_sel", drive_sel, m_drv);
    cmp("head_sel", head_sel, m_head);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic go(bit ec, int drv, bit hd, int ss, int eot, int sc, int spp);
    mode_drv_head = {ec, 4'b0, hd, 2'(drv)};
    start_sector = 8'(ss); eot_sector = 8'(eot); sec_count = 8'(sc); sectors_per_side = 8'(spp);
    start = 1; tick(1); start = 0;
  endtask

  task automatic pulses(int n, int gap, bit tc);
    for (int i = 0; i < n; i++) begin
      sector_checked = 1; tick(1); sector_checked = 0;
      term_count = tc; tick(gap); term_count = 0;
    end
  endtask

  task automatic finish_cmd();
    for (int i = 0; i < 2000 && ph != 0; i++) begin
      sector_checked = 1; tick(1);
    end
    sector_checked = 0; tick(2);
  endtask

  initial begin
    tick(3);
    checks++; if (busy || done || status != 0 || cur_sector != 0) begin errors++;
      $display("FAIL R10 reset: actual busy=%0d done=%0d status=%0d expected 0 0 0", busy, done, status); end
    rst_n = 1; tick(2);

    req = "R1/R2";  go(1, 2, 1, 3, 18, 5, 18); tick(2); pulses(5, 2, 0); tick(3);
    req = "R7";     tick(2);
    req = "R3";     go(1, 1, 0, 1, 18, 0, 18); tick(2); pulses(260, 0, 0); tick(3);
    req = "R4";     go(0, 3, 1, 1, 9, 8'hFF, 18); tick(2); pulses(12, 1, 0); tick(3);
    req = "R4";     go(0, 0, 0, 5, 5, 2, 5); tick(2); pulses(3, 1, 0); tick(3);
    req = "R5";     go(1, 0, 1, 2, 10, 4, 10); tick(2); term_count = 1; tick(4); term_count = 0;
                    pulses(5, 2, 1); tick(3);
    req = "R6";     go(1, 1, 1, 7, 19, 3, 18); pulses(2, 1, 0); tick(3);
    req = "R6";     go(0, 2, 0, 4, 18, 3, 18); tick(2); finish_cmd();
    req = "R8";     go(1, 3, 0, 250, 18, 10, 18); tick(2); pulses(10, 1, 0); tick(3);
    req = "R9";     pulses(3, 1, 0);
                    go(1, 1, 0, 2, 9, 6, 9); tick(2); pulses(2, 1, 0);
                    go(0, 2, 1, 40, 60, 1, 80); pulses(4, 1, 0); tick(3);
    req = "R10";    go(1, 0, 0, 0, 0, 1, 0); tick(3); pulses(1, 3, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule